// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Clock Divider

This block is a memory-mapped watchdog. The input clock first passes through a programmable 8-bit prescaler. A fixed power-of-two divider then slows it further, and the result is a one-cycle tick enable. Each tick decrements a 16-bit down-counter. When a tick finds the counter at zero, the counter reloads from the reload register. If both the run bit and the reset-arm bit are set at that moment, the block also emits a one-cycle system reset pulse.

Software keeps the system alive by writing the count register before the countdown runs out. The reload value is protected: it can only be changed while the timer is stopped. The bus port is a plain single-cycle register interface with three word registers, and every register can be read back.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control reads 0, reload reads 0xFFFF, count reads 0xFFFF and `wdog_rst_o` is low. Word index 0 is control, 1 is reload and 2 is count.
- R2: While the run bit (control bit 0) is set, a tick occurs every (P+1)·(16<<S) clock cycles, where P is control bits 15:8 and S is control bits 3:2. The first tick comes that many cycles after the edge that sets the run bit. The counter changes only on a tick or a count write.
- R3: A write to the count register loads the low 16 bits of write data at that edge, and the value reads back in the next cycle. A count write takes priority over a tick in the same cycle, and it suppresses any expiry in that cycle.
- R4: A write to the reload register takes effect only while the run bit is 0. While the run bit is set, such a write leaves the reload value unchanged.
- R5: A tick that finds the counter at 0 reloads it from the reload register. A loaded value N therefore expires after N+1 ticks.
- R6: `wdog_rst_o` is high for exactly one cycle, in the cycle after the expiring edge. It is raised only when control bit 0 (run) and bit 1 (reset-arm) are both set.
- R7: Clearing the run bit freezes the counter and clears the divider phase. After the timer is re-enabled, the first tick comes a full tick period later.
- R8: The sequence "write 0 to control, write 1 to count, write 3 to control" produces a reset pulse exactly two tick periods after the arming write.
- R9: Word index 3 reads as 0, and unused control bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdog_rst_o | output | 1 | One-cycle system reset request |

## Verification
The assertions check the cycle-level rules on every cycle. A count write lands at the next edge. An expiring tick reloads the counter. The counter holds between events, the reset pulse never lasts two cycles and always had the reset-arm bit behind it, ticks are never adjacent, and reload writes are ignored while the timer runs.

Only the bench scenarios can show the absolute timing of each reset pulse, predicted from the prescaler and select settings. The same holds for servicing holding off expiry, the frozen count while stopped, and the forced-reset sequence. A scoreboard predicts every pulse cycle and flags any pulse it did not expect.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_NONE   = 2'd3
  } wdog_reg_e;

  // control word layout
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_ARM_BIT = 1;
  localparam int CTRL_SEL_LSB = 2;
  localparam int CTRL_PSC_LSB = 8;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic              ctrl_run,
  output logic              ctrl_arm,
  output logic [SEL_W-1:0]  ctrl_sel,
  output logic [PSC_W-1:0]  ctrl_psc,
  output logic [CNT_W-1:0]  reload_val,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val
);
  logic             run_q, run_d, arm_q, arm_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] rld_q, rld_d;
  logic             wr_en;
  wdog_reg_e        idx;
  logic             unused_wdata;

  assign idx          = wdog_reg_e'(bus_addr);
  assign wr_en        = bus_sel && bus_wr;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    run_d = run_q;
    arm_d = arm_q;
    sel_d = sel_q;
    psc_d = psc_q;
    rld_d = rld_q;
    if (wr_en && idx == REG_CTRL) begin
      run_d = bus_wdata[CTRL_RUN_BIT];
      arm_d = bus_wdata[CTRL_ARM_BIT];
      sel_d = bus_wdata[CTRL_SEL_LSB +: SEL_W];
      psc_d = bus_wdata[CTRL_PSC_LSB +: PSC_W];
    end
    if (wr_en && idx == REG_RELOAD && !run_q) begin
      rld_d = bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      arm_q <= 1'b0;
      sel_q <= '0;
      psc_q <= '0;
      rld_q <= '1;
    end else begin
      run_q <= run_d;
      arm_q <= arm_d;
      sel_q <= sel_d;
      psc_q <= psc_d;
      rld_q <= rld_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (idx)
      REG_CTRL: begin
        bus_rdata[CTRL_RUN_BIT]              = run_q;
        bus_rdata[CTRL_ARM_BIT]              = arm_q;
        bus_rdata[CTRL_SEL_LSB +: SEL_W]     = sel_q;
        bus_rdata[CTRL_PSC_LSB +: PSC_W]     = psc_q;
      end
      REG_RELOAD: bus_rdata[CNT_W-1:0] = rld_q;
      REG_COUNT:  bus_rdata[CNT_W-1:0] = cnt_val;
      default:    bus_rdata = '0;
    endcase
  end

  assign ctrl_run     = run_q;
  assign ctrl_arm     = arm_q;
  assign ctrl_sel     = sel_q;
  assign ctrl_psc     = psc_q;
  assign reload_val   = rld_q;
  assign cnt_load     = wr_en && idx == REG_COUNT;
  assign cnt_load_val = bus_wdata[CNT_W-1:0];

  // R4: reload register is locked while the timer runs
  a_r4_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == REG_RELOAD && run_q) |=> $stable(rld_q));
endmodule

// File: rtl/wdog_divider.sv
module wdog_divider #(
  parameter int PSC_W      = 8,
  parameter int SEL_W      = 2,
  parameter int BASE_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int FIX_W = BASE_SHIFT + NSEL - 1;

  logic [PSC_W-1:0] pre_q, pre_d;
  logic [FIX_W-1:0] fix_q, fix_d, fix_last;
  logic             pre_hit, fix_hit;

  // terminal value of the fixed stage for each select code
  always_comb begin
    fix_last = '0;
    for (int i = 0; i < NSEL; i++) begin
      if (sel == i[SEL_W-1:0]) fix_last = FIX_W'((1 << (BASE_SHIFT + i)) - 1);
    end
  end

  assign pre_hit = pre_q >= psc;
  assign fix_hit = fix_q >= fix_last;
  assign tick    = run && pre_hit && fix_hit;

  always_comb begin
    pre_d = pre_q;
    fix_d = fix_q;
    if (!run) begin
      pre_d = '0;
      fix_d = '0;
    end else if (pre_hit) begin
      pre_d = '0;
      fix_d = fix_hit ? '0 : fix_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      fix_q <= '0;
    end else begin
      pre_q <= pre_d;
      fix_q <= fix_d;
    end
  end

  // R2: ticks are at least 16 cycles apart, never back to back
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R7: stopping clears the divider phase
  a_r7_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0 && fix_q == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             arm,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_pulse
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             expire;

  assign expire = tick && !load && cnt_q == '0;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = expire && run && arm;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      cnt_d = (cnt_q == '0) ? reload : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign cnt       = cnt_q;
  assign rst_pulse = pulse_q;

  // R3: a count write lands at the next edge
  a_r3_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
  // R5: expiry reloads the counter
  a_r5_expiry_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q == '0) |=> cnt_q == $past(reload));
  // R2: counter holds between ticks and writes
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  // R6: single-cycle pulse, only with reset-arm set
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  a_r6_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(arm && run));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int PSC_W      = 8,
  parameter int SEL_W      = 2,
  parameter int BASE_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdog_rst_o
);
  logic [1:0]       sync_q;
  logic             rst_s_n;
  logic             run, arm, tick, load;
  logic [SEL_W-1:0] sel;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] reload, load_val, cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s_n = sync_q[1];

  wdog_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt),
    .ctrl_run(run), .ctrl_arm(arm), .ctrl_sel(sel), .ctrl_psc(psc),
    .reload_val(reload), .cnt_load(load), .cnt_load_val(load_val)
  );

  wdog_divider #(.PSC_W(PSC_W), .SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) u_div (
    .clk(clk), .rst_n(rst_s_n), .run(run), .psc(psc), .sel(sel), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .run(run), .arm(arm),
    .load(load), .load_val(load_val), .reload(reload),
    .cnt(cnt), .rst_pulse(wdog_rst_o)
  );
endmodule

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        wdog_rst_o;

  int errors = 0, checks = 0, cyc = 0, pulses = 0;
  bit done = 0, live = 0;
  int exp_q[$];

  localparam int LIMIT = 150000;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_timer i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdog_rst_o(wdog_rst_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // called at a negedge; returns the edge index that captures the write
  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int edge_no);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    edge_no = cyc + 1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // monitor: every reset pulse must match the scoreboard
  always @(negedge clk) begin
    if (live && wdog_rst_o) begin
      pulses++;
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected pulse", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R6 pulse cycle", cyc, e);
      end
    end
  end

  always @(posedge clk) begin
    if (!done && cyc > LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int e, w, k, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1;

    // R1 / R9 reset state
    rd(2'd0, v); chk(v == 32'h0, "R1 ctrl", v, 0);
    rd(2'd1, v); chk(v == 32'hFFFF, "R1 reload", v, 32'hFFFF);
    rd(2'd2, v); chk(v == 32'hFFFF, "R1 count", v, 32'hFFFF);
    chk(wdog_rst_o == 1'b0, "R1 rst low", wdog_rst_o, 0);
    rd(2'd3, v); chk(v == 32'h0, "R9 spare index", v, 0);

    // R4 R5 R6: armed run, reload 3, start count 2, D=16
    wr(2'd1, 32'h3, e); rd(2'd1, v); chk(v == 32'h3, "R4 reload while stopped", v, 3);
    wr(2'd2, 32'hABC0_0002, e); rd(2'd2, v); chk(v == 32'h2, "R3 count write", v, 2);
    wr(2'd0, 32'hFFFF_00F3, e);
    rd(2'd0, v); chk(v == 32'h3, "R9 ctrl readback", v, 3);
    exp_q.push_back(e + 48); exp_q.push_back(e + 112);
    wait_until(e + 15); rd(2'd2, v); chk(v == 32'h2, "R2 before first tick", v, 2);
    wait_until(e + 16); rd(2'd2, v); chk(v == 32'h1, "R2 first tick", v, 1);
    wr(2'd1, 32'h9, w); rd(2'd1, v); chk(v == 32'h3, "R4 reload locked", v, 3);
    wait_until(e + 49); rd(2'd2, v); chk(v == 32'h3, "R5 reload on expiry", v, 3);
    wait_until(e + 114); wr(2'd0, 32'h0, w);
    drained("R5 R6 two pulses");

    // R6 gating: run without reset-arm
    p0 = pulses;
    wr(2'd1, 32'h5, w); wr(2'd2, 32'h0, w); wr(2'd0, 32'h1, e);
    wait_until(e + 16); rd(2'd2, v); chk(v == 32'h5, "R5 reload unarmed", v, 5);
    wait_until(e + 20); wr(2'd0, 32'h0, w);
    chk(pulses == p0, "R6 no pulse unarmed", pulses, p0);

    // R7 freeze and phase clear
    wr(2'd2, 32'h40, w); wr(2'd0, 32'h3, e);
    wait_until(e + 40); wr(2'd0, 32'h0, w);
    rd(2'd2, v); chk(v == 32'h3E, "R7 stopped value", v, 32'h3E);
    wait_until(cyc + 100); rd(2'd2, v); chk(v == 32'h3E, "R7 frozen", v, 32'h3E);
    wr(2'd0, 32'h3, e);
    wait_until(e + 15); rd(2'd2, v); chk(v == 32'h3E, "R7 phase cleared", v, 32'h3E);
    wait_until(e + 16); rd(2'd2, v); chk(v == 32'h3D, "R7 tick after restart", v, 32'h3D);
    wr(2'd0, 32'h0, w);

    // R2 prescaler 2, select 1: D=96
    wr(2'd1, 32'h0, w); wr(2'd2, 32'h0, w); wr(2'd0, 32'h0000_0207, e);
    exp_q.push_back(e + 96); exp_q.push_back(e + 192);
    wait_until(e + 194); wr(2'd0, 32'h0, w);
    drained("R2 psc2 sel1");
    // prescaler 1, select 3: D=256
    wr(2'd2, 32'h0, w); wr(2'd0, 32'h0000_010F, e);
    exp_q.push_back(e + 256);
    wait_until(e + 258); wr(2'd0, 32'h0, w);
    drained("R2 psc1 sel3");

    // R3 servicing holds off expiry
    wr(2'd1, 32'h2, w); wr(2'd2, 32'h3, w); wr(2'd0, 32'h3, e);
    for (int i = 0; i < 6; i++) begin
      wait_until(cyc + 40);
      wr(2'd2, 32'h3, w);
    end
    k = (w - e) / 16 + 1;
    exp_q.push_back(e + 16 * k + 48);
    wait_until(e + 16 * k + 50); wr(2'd0, 32'h0, w);
    drained("R3 service then expiry");

    // R8 forced reset sequence
    wr(2'd0, 32'h0, w); wr(2'd2, 32'h1, w); wr(2'd0, 32'h3, e);
    exp_q.push_back(e + 32);
    wait_until(e + 34); wr(2'd0, 32'h0, w);
    drained("R8 forced reset");

    repeat (5) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule